// File: doc/BRIEF.md
# Atomic-Update Status Register with Interrupt Level

This block holds one 64-bit status word on a register bus. Each access moves a whole 8-byte big-endian word, so bit 63 is the most significant bit of the data bus. The word can be reached at three consecutive word offsets. The first offset gives a plain read and a plain write. The second offset is a modify alias. The third offset is an OR alias that sets bits. A build-time parameter selects what the modify alias does. With `CLEAR_MODE = 0` it ANDs the write data into the word, at word offsets 0x4020 (plain), 0x4021 (AND) and 0x4022 (OR). With `CLEAR_MODE = 1` it wipes the word to zero and ignores the write data, at word offsets 0x6080 (plain), 0x6081 (clear) and 0x6082 (OR).

Only the upper 16 bits of the word are kept. The top stored bit is presented as a level interrupt and is driven from a flop. Software uses the OR alias to raise flags without a read-modify-write. It uses the modify alias to drop flags. Plain writes load the whole word. Any access the block does not decode leaves the state alone. Such an access raises a one-cycle flag that surrounding logic can count or report.

The request side uses a valid/ready handshake. `req_ready` is always high, so a request is taken in every cycle that `req_valid` is high. The response to a read comes exactly one cycle later on `rsp_valid` and cannot be back-pressured. The user of the block must therefore be able to take a response in the cycle after each read.

Top module: `atomic_status_reg`

## Requirements
- R1: After reset the stored word is zero, `irq_o` is low, and `rsp_valid` and `unimp_o` are low.
- R2: A write to the plain offset stores the write data with bits 47:0 forced to zero. A read at the plain offset returns the stored word on `rsp_data`, with `rsp_valid` high, in the cycle after the request.
- R3: A write to the OR offset stores (current | wdata) with bits 47:0 forced to zero.
- R4: With `CLEAR_MODE = 0`, a write to the modify offset stores (current & wdata) with bits 47:0 forced to zero.
- R5: With `CLEAR_MODE = 1`, a write to the modify offset sets the stored word to zero for any write data.
- R6: `irq_o` equals bit 63 of the stored word after every update. It rises when that bit is set and falls when that bit is cleared.
- R7: A read at the modify or OR offset, or at any undecoded address, returns zero with `rsp_valid` high one cycle later.
- R8: A write to an address other than the three offsets leaves the stored word and `irq_o` unchanged. A byte address whose bits 2:0 are not zero counts as undecoded.
- R9: `unimp_o` is high for exactly the one cycle after an undecoded access. An undecoded access is a read at any address except the plain offset, or a write outside the three offsets. `unimp_o` is low after every decoded access and after idle cycles.
- R10: `req_ready` is always high. `rsp_valid` is high exactly in the cycles that follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; the word offset is bits above 2 |
| req_wdata | input | DATA_W | Write data, bit 63 is the most significant |
| rsp_valid | output | 1 | Read response present, one cycle after a read |
| rsp_data | output | DATA_W | Read data |
| unimp_o | output | 1 | One-cycle flag for an undecoded access |
| irq_o | output | 1 | Interrupt level, equal to stored bit 63 |

## Verification
The assertions check the following on every cycle. Bits 47:0 of the stored word stay zero. The interrupt tracks the top stored bit. Idle cycles and undecoded writes hold the word. OR writes keep the bits they set. A clear in the clearing variant leaves zero. Read responses and the undecoded-access flag appear only one cycle after a request. Alias reads return zero. Only the bench's scenarios can show the following: the exact stored values after chains of mixed plain, AND, OR and clear writes, readback through the plain offset, and the interrupt falling after an AND or clear. The bench covers both build variants side by side.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // Kind of access after address decode.
  typedef enum logic [2:0] {
    K_IDLE     = 3'd0,
    K_WR_PLAIN = 3'd1,
    K_WR_MOD   = 3'd2,
    K_WR_OR    = 3'd3,
    K_RD_PLAIN = 3'd4,
    K_RD_ZERO  = 3'd5,  // read of an alias or unknown offset
    K_WR_UNDEC = 3'd6
  } acc_kind_e;

  // Byte address to word address shift for 8-byte accesses.
  localparam int unsigned WORD_SHIFT = 3;

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BASE_WORD = 32'h4020
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o
);
  localparam int unsigned WORD_W = ADDR_W - WORD_SHIFT;
  localparam logic [WORD_W-1:0] W_PLAIN = WORD_W'(BASE_WORD);
  localparam logic [WORD_W-1:0] W_MOD   = WORD_W'(BASE_WORD + 1);
  localparam logic [WORD_W-1:0] W_OR    = WORD_W'(BASE_WORD + 2);

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              hit_plain, hit_mod, hit_or;

  assign word      = addr_i[ADDR_W-1:WORD_SHIFT];
  assign aligned   = (addr_i[WORD_SHIFT-1:0] == '0);
  assign hit_plain = aligned && (word == W_PLAIN);
  assign hit_mod   = aligned && (word == W_MOD);
  assign hit_or    = aligned && (word == W_OR);

  always_comb begin
    kind_o = K_IDLE;
    if (valid_i) begin
      if (write_i) begin
        if (hit_plain)    kind_o = K_WR_PLAIN;
        else if (hit_mod) kind_o = K_WR_MOD;
        else if (hit_or)  kind_o = K_WR_OR;
        else              kind_o = K_WR_UNDEC;
      end else begin
        kind_o = hit_plain ? K_RD_PLAIN : K_RD_ZERO;
      end
    end
  end
endmodule

// File: rtl/sreg_update.sv
module sreg_update
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned KEEP_BITS  = 16,
  parameter bit          CLEAR_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  localparam int unsigned DROP_BITS = DATA_W - KEEP_BITS;
  localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_BITS{1'b1}}, {DROP_BITS{1'b0}}};

  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] mod_val;
  logic [DATA_W-1:0] raw_next;
  logic [DATA_W-1:0] next_val;
  logic              upd;
  logic              irq_q;

  // The modify alias is chosen at build time.
  generate
    if (CLEAR_MODE) begin : g_clear
      assign mod_val = '0;
    end else begin : g_and
      assign mod_val = status_q & wdata_i;
    end
  endgenerate

  always_comb begin
    upd      = 1'b1;
    raw_next = status_q;
    unique case (kind_i)
      K_WR_PLAIN: raw_next = wdata_i;
      K_WR_MOD:   raw_next = mod_val;
      K_WR_OR:    raw_next = status_q | wdata_i;
      default:    upd      = 1'b0;
    endcase
  end

  // Every update path passes the storage mask.
  assign next_val = raw_next & KEEP_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else if (upd) begin
      status_q <= next_val;
      irq_q    <= next_val[DATA_W-1];
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/sreg_readback.sv
module sreg_readback
  import sreg_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              unimp_o
);
  logic is_read, is_undec;

  assign is_read  = (kind_i == K_RD_PLAIN) || (kind_i == K_RD_ZERO);
  assign is_undec = (kind_i == K_RD_ZERO) || (kind_i == K_WR_UNDEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      unimp_o     <= 1'b0;
    end else begin
      rsp_valid_o <= is_read;
      rsp_data_o  <= (kind_i == K_RD_PLAIN) ? status_i : '0;
      unimp_o     <= is_undec;
    end
  end
endmodule

// File: rtl/atomic_status_reg.sv
module atomic_status_reg
  import sreg_pkg::*;
#(
  parameter bit          CLEAR_MODE = 1'b0,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned KEEP_BITS  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              unimp_o,
  output logic              irq_o
);
  localparam int unsigned BASE_WORD = CLEAR_MODE ? 32'h6080 : 32'h4020;

  acc_kind_e         kind;
  logic [DATA_W-1:0] status_q;

  assign req_ready = 1'b1;

  sreg_decode #(.ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD)) u_decode (
    .valid_i (req_valid),
    .write_i (req_write),
    .addr_i  (req_addr),
    .kind_o  (kind)
  );

  sreg_update #(.DATA_W(DATA_W), .KEEP_BITS(KEEP_BITS), .CLEAR_MODE(CLEAR_MODE)) u_update (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind_i   (kind),
    .wdata_i  (req_wdata),
    .status_o (status_q),
    .irq_o    (irq_o)
  );

  sreg_readback #(.DATA_W(DATA_W)) u_readback (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind_i      (kind),
    .status_i    (status_q),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data),
    .unimp_o     (unimp_o)
  );
endmodule

// File: rtl/sreg_checker.sv
module sreg_checker #(
  parameter bit          CLEAR_MODE = 1'b0,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned KEEP_BITS  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              unimp_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] status_q
);
  localparam logic [ADDR_W-1:0] A_PLAIN = ADDR_W'((CLEAR_MODE ? 32'h6080 : 32'h4020) * 8);
  localparam logic [ADDR_W-1:0] A_MOD   = A_PLAIN + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_OR    = A_PLAIN + ADDR_W'(16);
  localparam logic [DATA_W-1:0] KMASK   = {{KEEP_BITS{1'b1}}, {(DATA_W-KEEP_BITS){1'b0}}};

  logic rd_acc, wr_acc, plain_hit, or_hit, mod_hit;
  assign rd_acc    = req_valid && !req_write;
  assign wr_acc    = req_valid && req_write;
  assign plain_hit = (req_addr == A_PLAIN);
  assign mod_hit   = (req_addr == A_MOD);
  assign or_hit    = (req_addr == A_OR);

  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~KMASK) == '0);

  p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == status_q[DATA_W-1]);

  p_or_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && or_hit) |=> ((status_q & $past(req_wdata & KMASK)) == $past(req_wdata & KMASK)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (CLEAR_MODE && wr_acc && mod_hit) |=> (status_q == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc || !(plain_hit || mod_hit || or_hit)) |=> $stable(status_q));

  p_alias_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && !plain_hit) |=> (rsp_valid && rsp_data == '0));

  p_rsp_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);

  p_unimp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !unimp_o);
endmodule

bind atomic_status_reg sreg_checker #(
  .CLEAR_MODE(CLEAR_MODE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP_BITS(KEEP_BITS)
) u_sreg_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .unimp_o(unimp_o), .irq_o(irq_o), .status_q(status_q)
);

// File: tb/test_atomic_status_reg.sv
module test_atomic_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [DW-1:0] KMASK = 64'hFFFF_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          v[2], w[2];
  logic [AW-1:0] a[2];
  logic [DW-1:0] d[2];
  logic          rdy[2], rv[2], un[2], irq[2];
  logic [DW-1:0] rd[2];

  atomic_status_reg #(.CLEAR_MODE(1'b0)) i_atomic_status_reg (
    .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_ready(rdy[0]), .req_write(w[0]),
    .req_addr(a[0]), .req_wdata(d[0]), .rsp_valid(rv[0]), .rsp_data(rd[0]),
    .unimp_o(un[0]), .irq_o(irq[0]));

  atomic_status_reg #(.CLEAR_MODE(1'b1)) i_atomic_status_reg_clr (
    .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_ready(rdy[1]), .req_write(w[1]),
    .req_addr(a[1]), .req_wdata(d[1]), .rsp_valid(rv[1]), .rsp_data(rd[1]),
    .unimp_o(un[1]), .irq_o(irq[1]));

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] mdl[2];

  function automatic logic [AW-1:0] base_addr(input int u);
    return (u == 0) ? AW'(32'h4020 * 8) : AW'(32'h6080 * 8);
  endfunction

  // 0 plain, 1 modify, 2 OR, 3 other
  function automatic int slot(input int u, input logic [AW-1:0] addr);
    if (addr == base_addr(u))      return 0;
    if (addr == base_addr(u) + 8)  return 1;
    if (addr == base_addr(u) + 16) return 2;
    return 3;
  endfunction

  function automatic logic [DW-1:0] next_val(input int u, input logic [DW-1:0] cur,
                                             input int s, input logic [DW-1:0] wd);
    case (s)
      0: return wd & KMASK;
      1: return (u == 1) ? '0 : (cur & wd & KMASK);
      2: return (cur | wd) & KMASK;
      default: return cur;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access on unit u; checks response, flag, interrupt and readiness.
  task automatic access(input int u, input bit wr, input logic [AW-1:0] addr,
                        input logic [DW-1:0] wd, input string req);
    int s;
    logic [DW-1:0] exp_rd;
    bit exp_un;
    s = slot(u, addr);
    exp_rd = (!wr && s == 0) ? mdl[u] : '0;
    exp_un = wr ? (s == 3) : (s != 0);
    @(negedge clk);
    v[u] = 1'b1; w[u] = wr; a[u] = addr; d[u] = wd;
    chk(rdy[u] == 1'b1, "R10 ready", DW'(rdy[u]), 1);
    @(negedge clk);
    v[u] = 1'b0;
    if (wr) mdl[u] = next_val(u, mdl[u], s, wd);
    chk(rv[u] == !wr, {req, " rsp_valid"}, DW'(rv[u]), DW'(!wr));
    if (!wr) chk(rd[u] == exp_rd, {req, " rdata"}, rd[u], exp_rd);
    chk(un[u] == exp_un, {req, " R9 unimp"}, DW'(un[u]), DW'(exp_un));
    chk(irq[u] == mdl[u][63], {req, " R6 irq"}, DW'(irq[u]), DW'(mdl[u][63]));
  endtask

  task automatic readback(input int u, input string req);
    access(u, 1'b0, base_addr(u), '0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int u = 0; u < 2; u++) begin
      v[u] = 0; w[u] = 0; a[u] = '0; d[u] = '0; mdl[u] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(irq[u] == 0 && rv[u] == 0 && un[u] == 0, "R1 reset outputs",
          {61'd0, irq[u], rv[u], un[u]}, '0);
      readback(u, "R1 reset value");
    end

    for (int u = 0; u < 2; u++) begin
      // R2 plain write masks low bits
      access(u, 1'b1, base_addr(u), 64'h8123_4567_89AB_CDEF, "R2 plain write");
      readback(u, "R2 readback");
      // R3 OR sets bits
      access(u, 1'b1, base_addr(u) + 16, 64'h0040_FFFF_FFFF_FFFF, "R3 or write");
      readback(u, "R3 readback");
      // R7 alias reads give zero
      access(u, 1'b0, base_addr(u) + 8, '0, "R7 modify alias read");
      access(u, 1'b0, base_addr(u) + 16, '0, "R7 or alias read");
      access(u, 1'b0, base_addr(u) + 24, '0, "R7 unknown read");
      // R8 undecoded writes, including misaligned
      access(u, 1'b1, base_addr(u) - 8, '0, "R8 write below");
      access(u, 1'b1, base_addr(u) + 1, '0, "R8 misaligned write");
      access(u, 1'b1, base_addr(u) + 24, '1, "R8 write above");
      readback(u, "R8 held value");
      // modify alias: R4 on unit 0, R5 on unit 1; drops bit 63 -> R6 fall
      access(u, 1'b1, base_addr(u) + 8, 64'h7FFF_FFFF_FFFF_FFFF,
             (u == 0) ? "R4 and write" : "R5 clear write");
      readback(u, (u == 0) ? "R4 readback" : "R5 readback");
      chk(irq[u] == 1'b0, "R6 irq falls", DW'(irq[u]), 0);
      access(u, 1'b1, base_addr(u) + 16, 64'h8000_0000_0000_0000, "R6 irq rise");
      chk(irq[u] == 1'b1, "R6 irq high", DW'(irq[u]), 1);
      // R5 clear ignores all-ones data
      if (u == 1) begin
        access(u, 1'b1, base_addr(u) + 8, '1, "R5 clear ones");
        readback(u, "R5 zero after clear");
      end
    end

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int u, pick;
      logic [AW-1:0] ad;
      u = n % 2;
      pick = $urandom_range(0, 5);
      case (pick)
        0, 1: ad = base_addr(u);
        2:    ad = base_addr(u) + 8;
        3:    ad = base_addr(u) + 16;
        4:    ad = base_addr(u) + AW'($urandom_range(1, 7));
        default: ad = AW'($urandom) & ~AW'(7);
      endcase
      access(u, 1'($urandom_range(0, 1)), ad, {$urandom, $urandom}, "R2 random mix");
    end
    for (int u = 0; u < 2; u++) readback(u, "R3 final readback");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule